// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Mode and Partial Reset

This block buffers a stream of words between two unrelated clocks. The producer pushes words on its own clock with a write enable. The consumer pulls them on a second clock with a read enable. Each side has its own status outputs, computed only from state that lives in, or is synchronized into, that side's clock domain. The write and read counters cross between the domains as Gray code through two-stage synchronizers. Storage is an inferred dual-port array with a registered read port.

The read side works in one of two timing modes. In standard mode a word leaves the array only on a read strobe and appears on `rdata` one read clock later, and the two flags report full and empty. In fall-through mode the oldest word is moved to `rdata` without any strobe. The flags then report room to write and word available, and a read strobe consumes the word that is on display. The mode pin is sampled only while master reset is low. Each side also has an almost-threshold flag. Its offset register is loaded from that side's own load port, and master reset sets it to a default of 127.

The read side is a three-state machine. `RS_STD` is the only state in standard mode. In fall-through mode the machine moves between `RS_DRY` (nothing on display) and `RS_HELD` (a word on display):
- `DRY->HELD` when the array has a word.
- `HELD->HELD` on a strobe while the array still has words.
- `HELD->DRY` on a strobe when the array is empty.

Partial reset clears both counters, the synchronizers and the displayed word. It leaves the mode and both offsets as they were.

Top module: `afifo_dc`

## Requirements
- R1: After a master or partial reset the FIFO is empty and `r_almost_empty`=1, `w_almost_full`=0. In standard mode `wflag`=0 (not full), `rflag`=1 (empty) and `rdata`=0. In fall-through mode `wflag`=1 (room) and `rflag`=0 (no word).
- R2: In standard mode, a read strobe at a read clock edge while `rflag`=0 places the oldest stored word on `rdata` after that edge. Words leave in write order, and `rdata` holds its value when no read is done.
- R3: Once 2^ADDR_W words are stored in standard mode, `wflag` is 1. A write while full is dropped and never reaches the read side.
- R4: A read strobe while empty changes neither `rdata` nor the read position.
- R5: In fall-through mode the oldest word appears on `rdata` with `rflag`=1 and no strobe. It stays there until a read strobe, and `wflag`=1 means room.
- R6: `w_almost_full` is 1 exactly when free array locations (2^ADDR_W minus words written and not yet seen read) are less than or equal to the almost-full offset.
- R7: `r_almost_empty` is 1 exactly when the words the read side can see are less than or equal to the almost-empty offset. In fall-through mode this count includes the word on display.
- R8: Master reset sets both offsets to OFF_DEFAULT (127). A pulse on `af_ld` (write clock) or `ae_ld` (read clock) replaces the matching offset with `af_val` or `ae_val`.
- R9: `fwft_sel` is taken only while `mrst_n`=0 (1 selects fall-through). Changing it afterwards has no effect.
- R10: Partial reset (`prst_n`=0) empties the FIFO and keeps both offsets and the timing mode.
- R11: Each Gray counter changes in at most one bit per clock of its domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, held for several cycles of both clocks |
| prst_n | input | 1 | Partial reset, active low, held for several cycles of both clocks |
| fwft_sel | input | 1 | Timing mode taken during master reset: 1 fall-through, 0 standard |
| wen | input | 1 | Write enable |
| wdata | input | DATA_W | Write data |
| af_ld | input | 1 | Load almost-full offset (write clock) |
| af_val | input | ADDR_W | New almost-full offset |
| wflag | output | 1 | Standard: full. Fall-through: room to write |
| w_almost_full | output | 1 | Almost-full flag |
| ren | input | 1 | Read enable |
| ae_ld | input | 1 | Load almost-empty offset (read clock) |
| ae_val | input | ADDR_W | New almost-empty offset |
| rdata | output | DATA_W | Read data |
| rflag | output | 1 | Standard: empty. Fall-through: word available |
| r_almost_empty | output | 1 | Almost-empty flag |

## Verification
The bench fills the array to its last location and then keeps writing. A design that let a write through when full would wrap the write counter, and the read side would see a short or scrambled stream. Reads on an empty FIFO are followed by a real write and read: a read counter that slipped would hand back a stale word or show a false empty. The almost flags are checked one word either side of both the default and the loaded offsets, which exposes an off-by-one in the compare or a count that leaves out the displayed word. The bench also checks two kinds of state that must survive: a partial reset that cleared the offsets or the mode, and a mode pin that kept being sampled after reset. Either one shows as a wrong flag or as data falling through without a strobe.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    // Read-side presentation state
    typedef enum logic [1:0] {
        RS_STD  = 2'd0,   // standard timing: word leaves only on a strobe
        RS_DRY  = 2'd1,   // fall-through, nothing on display
        RS_HELD = 2'd2    // fall-through, a word is on display
    } rd_state_e;

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (clr) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rclr,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (rclr) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/afifo_wr.sv
module afifo_wr #(
    parameter int AW      = 8,
    parameter int OFF_DEF = 127
) (
    input  logic          wclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          fwft_sel,
    input  logic          wen,
    input  logic          af_ld,
    input  logic [AW-1:0] af_val,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wgray,
    output logic [AW:0]   wbin,
    output logic [AW-1:0] waddr,
    output logic          wr_go,
    output logic          wfull,
    output logic          wflag,
    output logic          af
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_V = {1'b1, {AW{1'b0}}};

    logic          clr;
    logic          fwft_q;
    logic [AW-1:0] off_q;
    logic [PW-1:0] wbin_nx;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] used;
    logic [PW-1:0] free;

    assign clr = !mrst_n || !prst_n;

    // Gray to binary for the synchronized read counter
    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign rbin_s[i] = ^rgray_s[PW-1:i];
    end

    // Configuration: mode and offset, touched by master reset only
    always_ff @(posedge wclk) begin
        if (!mrst_n) begin
            fwft_q <= fwft_sel;
            off_q  <= AW'(OFF_DEF);
        end else if (af_ld) begin
            off_q  <= af_val;
        end
    end

    assign wfull   = (wgray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
    assign wr_go   = wen && !wfull;
    assign wbin_nx = wbin + PW'(wr_go);

    always_ff @(posedge wclk) begin
        if (clr) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    assign waddr = wbin[AW-1:0];
    assign used  = wbin - rbin_s;
    assign free  = DEPTH_V - used;
    assign af    = (free <= {1'b0, off_q});
    assign wflag = fwft_q ? !wfull : wfull;
endmodule

// File: rtl/afifo_rd.sv
module afifo_rd
    import afifo_pkg::*;
#(
    parameter int AW      = 8,
    parameter int OFF_DEF = 127
) (
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          fwft_sel,
    input  logic          ren,
    input  logic          ae_ld,
    input  logic [AW-1:0] ae_val,
    input  logic [AW:0]   wgray_s,
    output logic [AW:0]   rgray,
    output logic [AW:0]   rbin,
    output logic [AW-1:0] raddr,
    output logic          fetch,
    output logic          ram_empty,
    output logic          fwft_mode,
    output logic          rflag,
    output logic          ae
);
    localparam int PW = AW + 1;
    localparam int CW = AW + 2;

    rd_state_e     st_q, st_nx;
    logic          clr;
    logic          mode_now;
    logic          held;
    logic [AW-1:0] off_q;
    logic [PW-1:0] rbin_nx;
    logic [PW-1:0] wbin_s;
    logic [CW-1:0] seen;

    assign clr = !mrst_n || !prst_n;

    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign wbin_s[i] = ^wgray_s[PW-1:i];
    end

    always_ff @(posedge rclk) begin
        if (!mrst_n) begin
            fwft_mode <= fwft_sel;
            off_q     <= AW'(OFF_DEF);
        end else if (ae_ld) begin
            off_q     <= ae_val;
        end
    end

    // During master reset the pin, not the register, picks the start state
    assign mode_now  = !mrst_n ? fwft_sel : fwft_mode;
    assign ram_empty = (rgray == wgray_s);

    // State register
    always_ff @(posedge rclk) begin
        if (clr) begin
            st_q <= mode_now ? RS_DRY : RS_STD;
        end else begin
            st_q <= st_nx;
        end
    end

    // Next state and array fetch
    always_comb begin
        st_nx = st_q;
        fetch = 1'b0;
        unique case (st_q)
            RS_STD: begin
                fetch = ren && !ram_empty;
            end
            RS_DRY: begin
                fetch = !ram_empty;
                st_nx = ram_empty ? RS_DRY : RS_HELD;
            end
            RS_HELD: begin
                if (ren) begin
                    fetch = !ram_empty;
                    st_nx = ram_empty ? RS_DRY : RS_HELD;
                end
            end
            default: begin
                st_nx = RS_STD;
            end
        endcase
    end

    // Outputs
    always_comb begin
        held  = (st_q == RS_HELD);
        rflag = (st_q == RS_STD) ? ram_empty : held;
    end

    assign rbin_nx = rbin + PW'(fetch);

    always_ff @(posedge rclk) begin
        if (clr) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    assign raddr = rbin[AW-1:0];
    assign seen  = {1'b0, wbin_s - rbin} + CW'(held);
    assign ae    = (seen <= CW'(off_q));
endmodule

// File: rtl/afifo_dc.sv
module afifo_dc #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 8,
    parameter int OFF_DEFAULT = 127
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              fwft_sel,
    input  logic              wen,
    input  logic [DATA_W-1:0] wdata,
    input  logic              af_ld,
    input  logic [ADDR_W-1:0] af_val,
    output logic              wflag,
    output logic              w_almost_full,
    input  logic              ren,
    input  logic              ae_ld,
    input  logic [ADDR_W-1:0] ae_val,
    output logic [DATA_W-1:0] rdata,
    output logic              rflag,
    output logic              r_almost_empty
);
    localparam int PW = ADDR_W + 1;

    logic              ptr_clr;
    logic [PW-1:0]     w_gray, w_bin, r_gray, r_bin;
    logic [PW-1:0]     w_gray_s, r_gray_s;
    logic [ADDR_W-1:0] w_addr, r_addr;
    logic              w_go, w_full;
    logic              r_fetch, r_empty, r_mode;

    assign ptr_clr = !mrst_n || !prst_n;

    afifo_sync #(.W(PW)) u_sync_r2w (
        .clk (wclk),
        .clr (ptr_clr),
        .d   (r_gray),
        .q   (r_gray_s)
    );

    afifo_sync #(.W(PW)) u_sync_w2r (
        .clk (rclk),
        .clr (ptr_clr),
        .d   (w_gray),
        .q   (w_gray_s)
    );

    afifo_wr #(.AW(ADDR_W), .OFF_DEF(OFF_DEFAULT)) u_wr (
        .wclk     (wclk),
        .mrst_n   (mrst_n),
        .prst_n   (prst_n),
        .fwft_sel (fwft_sel),
        .wen      (wen),
        .af_ld    (af_ld),
        .af_val   (af_val),
        .rgray_s  (r_gray_s),
        .wgray    (w_gray),
        .wbin     (w_bin),
        .waddr    (w_addr),
        .wr_go    (w_go),
        .wfull    (w_full),
        .wflag    (wflag),
        .af       (w_almost_full)
    );

    afifo_rd #(.AW(ADDR_W), .OFF_DEF(OFF_DEFAULT)) u_rd (
        .rclk      (rclk),
        .mrst_n    (mrst_n),
        .prst_n    (prst_n),
        .fwft_sel  (fwft_sel),
        .ren       (ren),
        .ae_ld     (ae_ld),
        .ae_val    (ae_val),
        .wgray_s   (w_gray_s),
        .rgray     (r_gray),
        .rbin      (r_bin),
        .raddr     (r_addr),
        .fetch     (r_fetch),
        .ram_empty (r_empty),
        .fwft_mode (r_mode),
        .rflag     (rflag),
        .ae        (r_almost_empty)
    );

    afifo_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk  (wclk),
        .we    (w_go),
        .waddr (w_addr),
        .wdata (wdata),
        .rclk  (rclk),
        .rclr  (ptr_clr),
        .re    (r_fetch),
        .raddr (r_addr),
        .rdata (rdata)
    );
endmodule

// File: rtl/afifo_dc_chk.sv
module afifo_dc_chk #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input logic          wclk,
    input logic          rclk,
    input logic          mrst_n,
    input logic          prst_n,
    input logic          wen,
    input logic          ren,
    input logic          wfull,
    input logic          rempty,
    input logic [AW:0]   wgray,
    input logic [AW:0]   wbin,
    input logic [AW:0]   rgray,
    input logic [AW:0]   rbin,
    input logic          rmode,
    input logic          rflag,
    input logic [DW-1:0] rdata
);
    // R3: a write while full leaves the write counter where it was
    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
        (wfull && wen) |=> $stable(wbin));

    // R4: nothing is fetched while the array is empty
    p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        rempty |=> $stable(rbin));

    // R11: write Gray counter moves one bit at a time
    p_wgray_step_r11: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
        $past(mrst_n && prst_n) |-> ($countones(wgray ^ $past(wgray)) <= 1));

    // R11: read Gray counter moves one bit at a time
    p_rgray_step_r11: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        $past(mrst_n && prst_n) |-> ($countones(rgray ^ $past(rgray)) <= 1));

    // R5: a displayed word stays until it is consumed
    p_fwft_hold_r5: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        (rmode && rflag && !ren) |=> (rflag && $stable(rdata)));

    // R9: the mode does not move outside master reset
    p_mode_stable_r9: assert property (@(posedge rclk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(rmode));

    // R10: partial reset leaves the read side empty
    p_prst_empty_r10: assert property (@(posedge rclk) disable iff (!mrst_n)
        !prst_n |=> rempty);
endmodule

bind afifo_dc afifo_dc_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
    .wclk   (wclk),
    .rclk   (rclk),
    .mrst_n (mrst_n),
    .prst_n (prst_n),
    .wen    (wen),
    .ren    (ren),
    .wfull  (w_full),
    .rempty (r_empty),
    .wgray  (w_gray),
    .wbin   (w_bin),
    .rgray  (r_gray),
    .rbin   (r_bin),
    .rmode  (r_mode),
    .rflag  (rflag),
    .rdata  (rdata)
);

// File: tb/tb_afifo_dc.sv
module tb_afifo_dc;
    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int DW    = 16;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int SEED  = 4711;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          mrst_n = 1'b0, prst_n = 1'b1, fwft_sel = 1'b0;
    logic          wen = 1'b0, af_ld = 1'b0, ren = 1'b0, ae_ld = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [AW-1:0] af_val = '0, ae_val = '0;
    logic          wflag, w_almost_full, rflag, r_almost_empty;
    logic [DW-1:0] rdata;

    int  n_chk = 0, n_fail = 0;
    bit  fwft_now = 1'b0;
    bit  finished = 1'b0;
    bit  wr_done;
    logic [DW-1:0] model [$];

    always #(CLK_PERIOD/2)  wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    afifo_dc #(.DATA_W(DW), .ADDR_W(AW), .OFF_DEFAULT(127)) dut (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
        .wen(wen), .wdata(wdata), .af_ld(af_ld), .af_val(af_val),
        .wflag(wflag), .w_almost_full(w_almost_full),
        .ren(ren), .ae_ld(ae_ld), .ae_val(ae_val),
        .rdata(rdata), .rflag(rflag), .r_almost_empty(r_almost_empty)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected acceptance of a write, from the flag meaning in each mode
    function automatic bit can_write(input bit fw, input logic flag);
        return fw ? flag : !flag;
    endfunction

    // Expected almost-empty flag for a visible count and offset
    function automatic bit exp_ae(input int cnt, input int off);
        return cnt <= off;
    endfunction

    task automatic mreset(input bit fw);
        @(negedge wclk);
        mrst_n = 1'b0; fwft_sel = fw; wen = 1'b0;
        repeat (6) @(negedge wclk);
        mrst_n = 1'b1; fwft_now = fw; model.delete();
        repeat (4) @(negedge rclk);
    endtask

    task automatic preset();
        @(negedge wclk);
        prst_n = 1'b0; wen = 1'b0;
        repeat (6) @(negedge wclk);
        prst_n = 1'b1; model.delete();
        repeat (4) @(negedge rclk);
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (4) @(negedge wclk);
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wclk);
        wen = 1'b1; wdata = d;
        if (can_write(fwft_now, wflag)) model.push_back(d);
        @(negedge wclk);
        wen = 1'b0;
    endtask

    task automatic pull(output logic [DW-1:0] d, output bit had);
        @(negedge rclk);
        if (fwft_now) begin
            had = rflag; d = rdata;
        end else begin
            had = !rflag;
        end
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
        if (!fwft_now) d = rdata;
    endtask

    task automatic pull_check(input string tag);
        logic [DW-1:0] d; bit had; logic [DW-1:0] e;
        pull(d, had);
        e = (model.size() > 0) ? model.pop_front() : '0;
        chk(had && d == e, tag, d, e);
    endtask

    task automatic rnd_writer(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wen = 1'($urandom_range(0, 1));
            wdata = DW'($urandom);
            if (wen && can_write(fwft_now, wflag)) model.push_back(wdata);
        end
        @(negedge wclk);
        wen = 1'b0;
        wr_done = 1'b1;
    endtask

    task automatic rnd_reader();
        bit pend = 1'b0;
        logic [DW-1:0] e;
        for (int c = 0; c < 40000; c++) begin
            @(negedge rclk);
            ren = 1'b0;
            if (fwft_now) begin
                if (rflag && model.size() > 0) begin
                    chk(rdata == model[0], "R5 random fall-through order", rdata, model[0]);
                    if ($urandom_range(0, 1) == 1) begin
                        ren = 1'b1;
                        void'(model.pop_front());
                    end
                end
            end else begin
                if (pend) begin
                    e = (model.size() > 0) ? model.pop_front() : '0;
                    chk(rdata == e, "R2 random standard order", rdata, e);
                end
                ren  = 1'($urandom_range(0, 1));
                pend = ren && !rflag;
            end
            if (wr_done && model.size() == 0 && !pend) break;
        end
        ren = 1'b0;
    endtask

    task automatic rnd_traffic(input int n);
        wr_done = 1'b0;
        fork
            rnd_writer(n);
            rnd_reader();
        join
        chk(model.size() == 0, "R2 random stream drained", model.size(), 0);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge wclk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d, w;
        bit had;
        void'($urandom(SEED));

        // ---------- standard mode ----------
        mreset(1'b0);
        chk(wflag == 1'b0, "R1 std not full", wflag, 0);
        chk(rflag == 1'b1, "R1 std empty", rflag, 1);
        chk(r_almost_empty == 1'b1, "R1 almost empty", r_almost_empty, 1);
        chk(w_almost_full == 1'b0, "R1 almost full low", w_almost_full, 0);
        chk(rdata == '0, "R1 rdata cleared", rdata, 0);

        // R4: read on empty
        pull(d, had);
        chk(rdata == '0, "R4 empty read leaves rdata", rdata, 0);
        chk(rflag == 1'b1, "R4 still empty", rflag, 1);
        push(16'hA5A5); settle();
        pull_check("R4 read position unmoved by empty read");

        // R2: in-order standard reads, hold without strobe
        for (int i = 0; i < 3; i++) push(DW'($urandom));
        settle();
        chk(rflag == 1'b0, "R2 not empty", rflag, 0);
        repeat (3) @(negedge rclk);
        chk(rdata == 16'hA5A5, "R2 rdata holds without read", rdata, 16'hA5A5);
        for (int i = 0; i < 3; i++) pull_check("R2 standard order");

        // R3 / R6: fill to depth and beyond
        settle();
        for (int i = 1; i <= DEPTH; i++) begin
            push(DW'($urandom));
            if (i == 128) chk(w_almost_full == 1'b0, "R6 free 128 above offset", w_almost_full, 0);
            if (i == 129) chk(w_almost_full == 1'b1, "R6 free 127 at offset", w_almost_full, 1);
            if (i == DEPTH - 1) chk(wflag == 1'b0, "R3 not full one short", wflag, 0);
        end
        chk(wflag == 1'b1, "R3 full at depth", wflag, 1);
        repeat (5) push(16'hDEAD);
        settle();
        for (int i = 0; i < DEPTH; i++) begin
            pull_check("R3 data intact after overflow attempts");
            if (DEPTH - 1 - i == 128)
                chk(r_almost_empty == exp_ae(128, 127), "R7 128 left", r_almost_empty, 0);
            if (DEPTH - 1 - i == 127)
                chk(r_almost_empty == exp_ae(127, 127), "R7 127 left", r_almost_empty, 1);
        end
        settle();
        chk(rflag == 1'b1, "R3 dropped writes never readable", rflag, 1);

        // R8: load offsets
        @(negedge wclk); af_ld = 1'b1; af_val = 8'd254;
        @(negedge wclk); af_ld = 1'b0;
        @(negedge rclk); ae_ld = 1'b1; ae_val = 8'd2;
        @(negedge rclk); ae_ld = 1'b0;
        for (int i = 0; i < 3; i++) push(DW'($urandom));
        settle();
        chk(r_almost_empty == exp_ae(3, 2), "R8 loaded ae offset", r_almost_empty, 0);
        chk(w_almost_full == 1'b1, "R8 loaded af offset", w_almost_full, 1);
        pull_check("R7 read at loaded offset");
        chk(r_almost_empty == exp_ae(2, 2), "R7 boundary at loaded offset", r_almost_empty, 1);
        pull_check("R2 drain"); pull_check("R2 drain");

        // R10: partial reset keeps offsets and mode
        for (int i = 0; i < 3; i++) push(DW'($urandom));
        settle();
        preset();
        chk(rflag == 1'b1, "R10 empty after partial reset", rflag, 1);
        chk(wflag == 1'b0, "R1 not full after partial reset", wflag, 0);
        chk(w_almost_full == 1'b0, "R1 af low after partial reset", w_almost_full, 0);
        for (int i = 0; i < 3; i++) push(DW'($urandom));
        settle();
        chk(r_almost_empty == 1'b0, "R10 ae offset kept", r_almost_empty, 0);
        chk(w_almost_full == 1'b1, "R10 af offset kept", w_almost_full, 1);
        chk(rflag == 1'b0, "R10 words visible", rflag, 0);
        chk(rdata == '0, "R10 standard timing kept", rdata, 0);
        for (int i = 0; i < 3; i++) pull_check("R10 data after partial reset");

        // ---------- fall-through mode ----------
        mreset(1'b1);
        chk(wflag == 1'b1, "R1 fwft room", wflag, 1);
        chk(rflag == 1'b0, "R1 fwft no word", rflag, 0);
        chk(r_almost_empty == 1'b1, "R1 fwft almost empty", r_almost_empty, 1);
        chk(w_almost_full == 1'b0, "R1 fwft almost full low", w_almost_full, 0);
        for (int i = 0; i < 3; i++) push(DW'($urandom));
        settle();
        chk(rflag == 1'b1, "R5 word available", rflag, 1);
        chk(rdata == model[0], "R5 first word without strobe", rdata, model[0]);
        chk(r_almost_empty == exp_ae(3, 127), "R8 default ae restored", r_almost_empty, 1);
        chk(w_almost_full == 1'b0, "R8 default af restored", w_almost_full, 0);
        repeat (4) @(negedge rclk);
        chk(rdata == model[0], "R5 word held", rdata, model[0]);
        for (int i = 0; i < 3; i++) pull_check("R5 fall-through order");
        settle();
        chk(rflag == 1'b0, "R5 no word when drained", rflag, 0);

        // R9: pin change after reset ignored
        fwft_sel = 1'b0;
        w = 16'h3C3C; push(w); settle();
        chk(rflag == 1'b1, "R9 mode unchanged flag", rflag, 1);
        chk(rdata == w, "R9 mode unchanged data", rdata, w);
        pull_check("R9 consume");

        // R10 in fall-through
        push(16'h1111); push(16'h2222); settle();
        preset();
        chk(rflag == 1'b0, "R10 fwft empty after partial reset", rflag, 0);
        chk(wflag == 1'b1, "R10 fwft room after partial reset", wflag, 1);
        w = 16'h7E81; push(w); settle();
        chk(rflag == 1'b1 && rdata == w, "R10 fall-through kept", rdata, w);
        pull_check("R10 consume");

        rnd_traffic(2500);

        // ---------- standard random ----------
        mreset(1'b0);
        rnd_traffic(2500);

        finished = 1'b1;
        report();
        $finish;
    end
endmodule